// File: doc/BRIEF.md
# I2C Target with Software Clock-Stretch Control

This block is the target side of an I2C bus. It watches the open-drain SCL and SDA lines, recognises its own address, acknowledges, and then either receives data bytes into a holding register or serialises a transmit byte back to the controller. The address can be 7 or 10 bits wide. The block can also answer the general call address, and it has a mode that acknowledges every address. Both lines are modelled as a sampled input plus an output enable. When an output enable is 1, the pad pulls that line low.

Software drives the block through a small word-wide register port. It sets a control word, the own address and the next byte to transmit, and it reads back the last received byte. A release bit in the control word decides whether SCL is free or held low. Hardware clears this bit at fixed points in a transfer, which makes the controller wait until software has serviced the byte. A stretch-enable bit selects one of two policies, and these differ in how software may write the release bit. A single-cycle interrupt pulse marks each event that needs service.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: With the enable bit (control bit 0) at 0, both output enables stay 0, no byte is acknowledged and no interrupt is raised.
- R2: After reset, the control word (register address 0) reads 0x0020: the release bit (bit 5) is 1 and all other control bits are 0.
- R3: In 7-bit mode (control bit 1 = 0), an address byte whose upper seven bits equal bits 6:0 of the own address (register address 1) is acknowledged. Each data byte that follows is acknowledged, and can then be read at register address 3.
- R4: A non-matching address byte is not acknowledged, and the bytes after it are ignored until the next START.
- R5: In 10-bit mode, a first byte of 11110, own address bits 9:8 and a write bit is acknowledged, and a second byte equal to own address bits 7:0 completes the match. After a repeated START, the same header with the read bit set starts a transmit.
- R6: With ack-all (control bit 2) set, any address byte is acknowledged.
- R7: With general-call enable (control bit 3) set, the address byte 0x00 is acknowledged and raises the interrupt. With the bit clear, 0x00 is not acknowledged.
- R8: While enabled, the block holds SCL low (scl_oe = 1) exactly when the release bit is 0.
- R9: An address match with the read bit set clears the release bit, whatever the stretch-enable setting.
- R10: With stretch-enable (control bit 4) set, completion of a received data byte clears the release bit, and software may write the release bit to 0 or to 1.
- R11: With stretch-enable clear, a software write of 0 to the release bit has no effect, and a received byte inserts no stretch.
- R12: The interrupt is a one-cycle pulse that follows an address match, a received data byte, and the acknowledge bit of each transmitted byte.
- R13: A transmit sends the byte at register address 2 MSB first. A controller acknowledge makes the block send it again, and a not-acknowledge makes the block release SDA.
- R14: A STOP (SDA rising while SCL is high) returns the block to idle, so that bytes clocked after it without a START are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 own address, 2 transmit byte, 3 received byte |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data for reg_addr |
| scl_i | input | 1 | Sampled SCL line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | One-cycle event pulse |

## Verification
The bench builds the block with its defaults: a two-stage line synchroniser and a 16-bit register port. That port is wide enough to show the full 10-bit own address and all six control bits in one read. A bit period of about 27 core clocks leaves room for the synchroniser delay, so the bench can see a stretch starting inside the ack bit that follows. This makes the hardware clears of the release bit observable from the bus, in both stretch policies, in 7-bit and 10-bit reads and writes.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int TADDR_W = 10;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = 4;

  // control word bit positions
  localparam int CB_EN  = 0;
  localparam int CB_TEN = 1;
  localparam int CB_ALL = 2;
  localparam int CB_GCE = 3;
  localparam int CB_STR = 4;
  localparam int CB_REL = 5;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_ADDR = 2'd1;
  localparam logic [1:0] RA_TX   = 2'd2;
  localparam logic [1:0] RA_RX   = 2'd3;

  typedef struct packed {
    logic rel;
    logic stren;
    logic gce;
    logic ackall;
    logic ten;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR2, S_RX, S_TX, S_SKIP
  } eng_st_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic rise,
  output logic fall,
  output logic start,
  output logic stop
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_s = scl_p[STAGES-1];
  assign sda_s = sda_p[STAGES-1];
  assign rise  = scl_s & ~scl_q;
  assign fall  = ~scl_s & scl_q;
  assign start = scl_s & scl_q & sda_q & ~sda_s;
  assign stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              tx_start,
  input  logic              rx_done,
  input  logic [BYTE_W-1:0] rx_byte,
  output ctrl_t             ctrl,
  output logic [TADDR_W-1:0] taddr,
  output logic [BYTE_W-1:0] tx_byte
);
  ctrl_t ctrl_q, ctrl_d;
  logic [TADDR_W-1:0] taddr_q, taddr_d;
  logic [BYTE_W-1:0]  txb_q, txb_d;
  logic unused_wbits;

  assign unused_wbits = ^wdata[REG_W-1:TADDR_W];

  always_comb begin
    ctrl_d  = ctrl_q;
    taddr_d = taddr_q;
    txb_d   = txb_q;
    if (wr) begin
      case (addr)
        RA_CTRL: begin
          ctrl_d.en     = wdata[CB_EN];
          ctrl_d.ten    = wdata[CB_TEN];
          ctrl_d.ackall = wdata[CB_ALL];
          ctrl_d.gce    = wdata[CB_GCE];
          ctrl_d.stren  = wdata[CB_STR];
          // policy of the stored stretch-enable decides the write rule
          ctrl_d.rel    = ctrl_q.stren ? wdata[CB_REL] : (ctrl_q.rel | wdata[CB_REL]);
        end
        RA_ADDR: taddr_d = wdata[TADDR_W-1:0];
        RA_TX:   txb_d   = wdata[BYTE_W-1:0];
        default: ;
      endcase
    end
    // hardware clears win over a same-cycle write
    if (tx_start || (rx_done && ctrl_q.stren)) ctrl_d.rel = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '{rel: 1'b1, default: 1'b0};
      taddr_q <= '0;
      txb_q   <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      taddr_q <= taddr_d;
      txb_q   <= txb_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_CTRL: rdata[CTRL_W-1:0]  = ctrl_q;
      RA_ADDR: rdata[TADDR_W-1:0] = taddr_q;
      RA_TX:   rdata[BYTE_W-1:0]  = txb_q;
      default: rdata[BYTE_W-1:0]  = rx_byte;
    endcase
  end

  assign ctrl    = ctrl_q;
  assign taddr   = taddr_q;
  assign tx_byte = txb_q;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               ten,
  input  logic               ackall,
  input  logic               gce,
  input  logic [TADDR_W-1:0] taddr,
  input  logic [BYTE_W-1:0]  tx_byte,
  input  logic               sda_s,
  input  logic               rise,
  input  logic               fall,
  input  logic               start,
  input  logic               stop,
  output logic               sda_oe,
  output logic               irq,
  output logic               rx_done,
  output logic               tx_start,
  output logic [BYTE_W-1:0]  rx_byte,
  output logic               busy
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(BYTE_W + 1);

  eng_st_t st_q, st_d, go_q, go_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, txs_q, txs_d, rx_q, rx_d;
  logic ack_q, ack_d, txo_q, txo_d, mn_q, mn_d, ten_q, ten_d;
  logic irq_q, irq_d, rxd_q, rxd_d, txst_q, txst_d;
  logic active, hit7, hdr;

  assign active = (st_q != S_IDLE) && (st_q != S_SKIP);
  assign hit7   = ackall || (gce && sh_q == '0) ||
                  (!ten && sh_q != '0 && sh_q[7:1] == taddr[6:0]);
  assign hdr    = ten && !ackall && sh_q[7:3] == 5'b11110 && sh_q[2:1] == taddr[9:8];

  always_comb begin
    st_d = st_q;  go_d = go_q;  cnt_d = cnt_q;  sh_d = sh_q;
    txs_d = txs_q; rx_d = rx_q; ack_d = ack_q;  txo_d = txo_q;
    mn_d = mn_q;  ten_d = ten_q;
    irq_d = 1'b0; rxd_d = 1'b0; txst_d = 1'b0;
    if (!en || stop) begin
      st_d = S_IDLE; cnt_d = '0; ack_d = 1'b0; txo_d = 1'b0; ten_d = 1'b0;
    end else if (start) begin
      st_d = S_ADDR; cnt_d = '0; ack_d = 1'b0; txo_d = 1'b0;
    end else if (rise && active) begin
      if (cnt_q < LAST_BIT) sh_d = {sh_q[BYTE_W-2:0], sda_s};
      else                  mn_d = sda_s;
      cnt_d = cnt_q + 1'b1;
    end else if (fall && active) begin
      if (cnt_q == LAST_BIT) begin
        case (st_q)
          S_ADDR: begin
            if (hit7) begin
              ack_d = 1'b1; irq_d = 1'b1; txst_d = sh_q[0];
              go_d = sh_q[0] ? S_TX : S_RX;
            end else if (hdr && !sh_q[0]) begin
              ack_d = 1'b1; go_d = S_ADDR2;
            end else if (hdr && ten_q) begin
              ack_d = 1'b1; irq_d = 1'b1; txst_d = 1'b1; go_d = S_TX;
            end else begin
              st_d = S_SKIP;
            end
          end
          S_ADDR2: begin
            if (sh_q == taddr[BYTE_W-1:0]) begin
              ack_d = 1'b1; irq_d = 1'b1; ten_d = 1'b1; go_d = S_RX;
            end else begin
              st_d = S_SKIP;
            end
          end
          S_RX: begin
            rx_d = sh_q; ack_d = 1'b1; irq_d = 1'b1; rxd_d = 1'b1; go_d = S_RX;
          end
          default: begin
            txo_d = 1'b0; go_d = S_TX;
          end
        endcase
      end else if (cnt_q == ACK_BIT) begin
        ack_d = 1'b0; cnt_d = '0;
        if (st_q == S_TX) irq_d = 1'b1;
        if (go_q == S_TX && st_q == S_TX && mn_q) begin
          st_d = S_SKIP; txo_d = 1'b0;
        end else if (go_q == S_TX) begin
          st_d = S_TX; txs_d = tx_byte; txo_d = ~tx_byte[BYTE_W-1];
        end else begin
          st_d = go_q;
        end
      end else if (st_q == S_TX && cnt_q != '0) begin
        txs_d = {txs_q[BYTE_W-2:0], 1'b0};
        txo_d = ~txs_q[BYTE_W-2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; go_q <= S_IDLE; cnt_q <= '0; sh_q <= '0;
      txs_q <= '0; rx_q <= '0; ack_q <= 1'b0; txo_q <= 1'b0;
      mn_q <= 1'b1; ten_q <= 1'b0;
      irq_q <= 1'b0; rxd_q <= 1'b0; txst_q <= 1'b0;
    end else begin
      st_q <= st_d; go_q <= go_d; cnt_q <= cnt_d; sh_q <= sh_d;
      txs_q <= txs_d; rx_q <= rx_d; ack_q <= ack_d; txo_q <= txo_d;
      mn_q <= mn_d; ten_q <= ten_d;
      irq_q <= irq_d; rxd_q <= rxd_d; txst_q <= txst_d;
    end
  end

  assign sda_oe   = en & (ack_q | txo_q);
  assign irq      = irq_q;
  assign rx_done  = rxd_q;
  assign tx_start = txst_q;
  assign rx_byte  = rx_q;
  assign busy     = st_q != S_IDLE;
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             scl_i,
  output logic             scl_oe,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic             irq
);
  logic [1:0] rst_pipe;
  logic rst_int;
  ctrl_t ctrl;
  logic [TADDR_W-1:0] taddr;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic sda_s, rise, fall, start, stop;
  logic rx_done, tx_start, busy;
  logic en_w, rel_w, stren_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .rise(rise), .fall(fall), .start(start), .stop(stop)
  );

  i2c_tgt_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_int), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .tx_start(tx_start),
    .rx_done(rx_done), .rx_byte(rx_byte), .ctrl(ctrl), .taddr(taddr),
    .tx_byte(tx_byte)
  );

  i2c_tgt_engine u_eng (
    .clk(clk), .rst_n(rst_int), .en(ctrl.en), .ten(ctrl.ten),
    .ackall(ctrl.ackall), .gce(ctrl.gce), .taddr(taddr), .tx_byte(tx_byte),
    .sda_s(sda_s), .rise(rise), .fall(fall), .start(start), .stop(stop),
    .sda_oe(sda_oe), .irq(irq), .rx_done(rx_done), .tx_start(tx_start),
    .rx_byte(rx_byte), .busy(busy)
  );

  assign en_w    = ctrl.en;
  assign rel_w   = ctrl.rel;
  assign stren_w = ctrl.stren;
  assign scl_oe  = en_w & ~rel_w;
endmodule

// File: rtl/i2c_tgt_stretch_chk.sv
module i2c_tgt_stretch_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic rel,
  input logic stren,
  input logic sda_oe,
  input logic scl_oe,
  input logic irq,
  input logic rx_done,
  input logic tx_start,
  input logic stop,
  input logic busy
);
  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!sda_oe && !scl_oe));

  p_tx_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !rel);

  p_rx_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && stren) |=> !rel);

  p_rel_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!stren && rel && !tx_start) |=> rel);

  p_irq_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_stop_idle_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && en) |=> !busy);
endmodule

bind i2c_tgt_stretch i2c_tgt_stretch_chk u_chk (
  .clk(clk), .rst_n(rst_int), .en(en_w), .rel(rel_w), .stren(stren_w),
  .sda_oe(sda_oe), .scl_oe(scl_oe), .irq(irq), .rx_done(rx_done),
  .tx_start(tx_start), .stop(stop), .busy(busy)
);

// File: tb/tb_i2c_tgt_stretch.sv
module tb_i2c_tgt_stretch;
  localparam int H = 12;
  localparam logic [1:0] A_CTRL = 2'd0, A_ADDR = 2'd1, A_TX = 2'd2, A_RX = 2'd3;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr;
  logic [1:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic scl_oe, sda_oe, irq;
  logic m_scl_lo, m_sda_lo;
  logic scl_line, sda_line;

  int nchk = 0, nbad = 0, irq_cnt = 0, exp_irq = 0;
  bit stretch_seen;
  bit rel_at_stretch;

  always #4 clk = ~clk;

  assign scl_line = !(m_scl_lo || scl_oe);
  assign sda_line = !(m_sda_lo || sda_oe);

  i2c_tgt_stretch dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_line),
    .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe), .irq(irq)
  );

  always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

  function automatic bit exp_hit7(input logic [7:0] b, input logic [6:0] own,
                                  input bit ten, input bit all, input bit gce);
    return all || (gce && b == 8'h00) || (!ten && b != 8'h00 && b[7:1] == own);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clkn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic scl_up();
    logic [15:0] c;
    int w;
    m_scl_lo = 1'b0;
    w = 0;
    while (!scl_line && w < 40) begin clkn(1); w++; end
    if (!scl_line) begin
      stretch_seen = 1'b1;
      reg_read(A_CTRL, c);
      rel_at_stretch = c[5];
      reg_write(A_CTRL, c | 16'h0020);
      w = 0;
      while (!scl_line && w < 1000) begin clkn(1); w++; end
    end
  endtask

  task automatic m_start();
    clkn(H); m_sda_lo = 1'b0; clkn(3);
    scl_up(); clkn(H);
    m_sda_lo = 1'b1; clkn(H);
    m_scl_lo = 1'b1;
  endtask

  task automatic m_stop();
    clkn(3); m_sda_lo = 1'b1; clkn(H);
    scl_up(); clkn(H);
    m_sda_lo = 1'b0; clkn(H);
  endtask

  task automatic bit_out(input logic b);
    clkn(3); m_sda_lo = !b; clkn(H);
    scl_up(); clkn(H);
    m_scl_lo = 1'b1;
  endtask

  task automatic bit_in(output logic b);
    clkn(3); m_sda_lo = 1'b0; clkn(H);
    scl_up(); clkn(H/2);
    b = sda_line;
    clkn(H/2);
    m_scl_lo = 1'b1;
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack_n);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(ack_n);
  endtask

  task automatic read_byte(output logic [7:0] b, input logic mack_n);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(mack_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic ackb;
    logic [7:0] rb;
    void'($urandom(32'd7));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    m_scl_lo = 1'b0; m_sda_lo = 1'b0;
    clkn(5); rst_n = 1'b1; clkn(5);

    // R2 reset values
    reg_read(A_CTRL, rd);
    check("R2 ctrl reset", rd, 16'h0020);
    check("R2 scl_oe reset", scl_oe, 0);

    // R1 disabled block stays off the bus
    reg_write(A_ADDR, 16'h002A);
    m_start(); write_byte(8'h54, ackb);
    check("R1 no ack when disabled", ackb, 1);
    check("R1 sda_oe off", sda_oe, 0);
    m_stop();
    check("R1 no irq", irq_cnt, exp_irq);

    // R3 7-bit write
    reg_write(A_CTRL, 16'h0021);
    m_start(); write_byte(8'h54, ackb);
    check("R3 address ack", ackb, 0);
    write_byte(8'hC3, ackb);
    check("R3 data ack", ackb, 0);
    reg_read(A_RX, rd);
    check("R3 rx byte", rd, 16'h00C3);
    m_stop(); exp_irq += 2;
    check("R12 irq after match and byte", irq_cnt, exp_irq);

    // R14 byte after STOP without START is ignored
    write_byte(8'h55, ackb);
    check("R14 ignored after stop", ackb, 1);
    m_stop();

    // R4 non-matching address
    m_start(); write_byte(8'h56, ackb);
    check("R4 address nack", ackb, 1);
    write_byte(8'h11, ackb);
    check("R4 data ignored", ackb, 1);
    reg_read(A_RX, rd);
    check("R4 rx unchanged", rd, 16'h00C3);
    m_stop();
    check("R4 no irq", irq_cnt, exp_irq);

    // R11 stretch disabled: writing 0 has no effect, no stretch on rx
    reg_write(A_CTRL, 16'h0001);
    reg_read(A_CTRL, rd);
    check("R11 release write 0 ignored", rd, 16'h0021);
    check("R8 scl free", scl_oe, 0);
    stretch_seen = 1'b0;
    m_start(); write_byte(8'h54, ackb); write_byte(8'h9E, ackb);
    m_stop(); exp_irq += 2;
    check("R11 no stretch after rx", stretch_seen, 0);

    // R8 / R10 stretch enabled
    reg_write(A_CTRL, 16'h0031);
    reg_write(A_CTRL, 16'h0011);
    reg_read(A_CTRL, rd);
    check("R10 release written 0", rd, 16'h0011);
    check("R8 scl held when release 0", scl_oe, 1);
    reg_write(A_CTRL, 16'h0031);
    check("R8 scl freed when release 1", scl_oe, 0);
    stretch_seen = 1'b0; rel_at_stretch = 1'b1;
    m_start(); write_byte(8'h54, ackb);
    check("R10 no stretch on address", stretch_seen, 0);
    write_byte(8'h6B, ackb);
    check("R10 stretch after rx byte", stretch_seen, 1);
    check("R10 release cleared by rx", rel_at_stretch, 0);
    check("R10 data ack", ackb, 0);
    m_stop(); exp_irq += 2;
    check("R12 irq count stretch write", irq_cnt, exp_irq);

    // R9 / R13 read with stretch disabled
    reg_write(A_CTRL, 16'h0021);
    reg_write(A_TX, 16'h00A6);
    stretch_seen = 1'b0; rel_at_stretch = 1'b1;
    m_start(); write_byte(8'h55, ackb);
    check("R9 read address ack", ackb, 0);
    check("R9 stretch at read start", stretch_seen, 1);
    check("R9 release cleared", rel_at_stretch, 0);
    read_byte(rb, 1'b0);
    check("R13 first tx byte", rb, 8'hA6);
    read_byte(rb, 1'b1);
    check("R13 repeated tx byte", rb, 8'hA6);
    m_stop(); exp_irq += 3;
    check("R13 sda released after nack", sda_oe, 0);
    check("R12 irq count read", irq_cnt, exp_irq);

    // R5 10-bit addressing, own address 0x2D7
    reg_write(A_ADDR, 16'h02D7);
    reg_write(A_CTRL, 16'h0023);
    m_start(); write_byte(8'hF4, ackb);
    check("R5 header ack", ackb, 0);
    write_byte(8'hD7, ackb);
    check("R5 low byte ack", ackb, 0);
    write_byte(8'h3C, ackb);
    reg_read(A_RX, rd);
    check("R5 rx byte", rd, 16'h003C);
    m_stop(); exp_irq += 2;
    m_start(); write_byte(8'hF4, ackb); write_byte(8'hD6, ackb);
    check("R5 wrong low byte nack", ackb, 1);
    m_stop();
    m_start(); write_byte(8'hAE, ackb);
    check("R5 7-bit form nack in 10-bit mode", ackb, 1);
    m_stop();
    check("R5 irq count", irq_cnt, exp_irq);
    reg_write(A_TX, 16'h0081);
    m_start(); write_byte(8'hF4, ackb); write_byte(8'hD7, ackb);
    m_start(); write_byte(8'hF5, ackb);
    check("R5 read header ack", ackb, 0);
    read_byte(rb, 1'b1);
    check("R5 10-bit read byte", rb, 8'h81);
    m_stop(); exp_irq += 3;
    check("R5 irq count read", irq_cnt, exp_irq);

    // R6 ack-all
    reg_write(A_ADDR, 16'h002A);
    reg_write(A_CTRL, 16'h0025);
    m_start(); write_byte(8'h9C, ackb);
    check("R6 any address acked", ackb, 0);
    m_stop(); exp_irq += 1;

    // R7 general call
    reg_write(A_CTRL, 16'h0029);
    m_start(); write_byte(8'h00, ackb);
    check("R7 general call ack", ackb, 0);
    write_byte(8'h77, ackb);
    reg_read(A_RX, rd);
    check("R7 general call data", rd, 16'h0077);
    m_stop(); exp_irq += 2;
    check("R7 irq count", irq_cnt, exp_irq);
    reg_write(A_CTRL, 16'h0021);
    m_start(); write_byte(8'h00, ackb);
    check("R7 general call ignored", ackb, 1);
    m_stop();
    check("R7 no irq when disabled", irq_cnt, exp_irq);

    // R3 / R4 random traffic
    for (int it = 0; it < 16; it++) begin
      logic [6:0] a7;
      logic [7:0] d;
      int nb;
      bit hit;
      a7 = ($urandom % 2 == 0) ? 7'h2A : 7'($urandom);
      if (a7 == 7'h00) a7 = 7'h01;
      hit = exp_hit7({a7, 1'b0}, 7'h2A, 1'b0, 1'b0, 1'b0);
      m_start(); write_byte({a7, 1'b0}, ackb);
      check(hit ? "R3 random address" : "R4 random address", ackb, hit ? 0 : 1);
      if (hit) exp_irq++;
      nb = 1 + int'($urandom % 3);
      for (int k = 0; k < nb; k++) begin
        d = 8'($urandom);
        write_byte(d, ackb);
        check(hit ? "R3 random data ack" : "R4 random data", ackb, hit ? 0 : 1);
        if (hit) begin
          exp_irq++;
          reg_read(A_RX, rd);
          check("R3 random rx byte", rd, {8'h00, d});
        end
      end
      m_stop();
      check("R12 random irq count", irq_cnt, exp_irq);
    end

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule